// File: doc/BRIEF.md
# Serial Flash Boot Fetch Controller with Descrambling

This block sits on the logic side of a two-die package. It drives a four-line serial flash bus, and it starts a fixed boot sequence as soon as reset is released. First it wakes the flash. Next it reads the factory configuration word, the boot loader region and the protection option word. After that it copies user firmware into an internal shadow RAM, one 1 KiB page per transaction.

Firmware is held in the flash in scrambled form. Inside each page the word order is shuffled by a fixed permutation of the eight word-index bits. Inside each word, every byte lane has its own bit shuffle. The block undoes both shuffles before it writes a word into the shadow RAM. The configuration word and the option word are taken as they arrive. The option word goes to the protection logic through a one-cycle valid strobe.

A parameter sets how many pages are loaded at boot. When it equals the page count, the whole image is copied at startup. When it is smaller, the remaining pages are loaded the first time a fetch asks for them. A fetch port reads the shadow RAM and holds the requester off with a ready signal until the page it needs is present.

Top module: `qfb_boot_fetch`

## Requirements
- R1: While reset is asserted, the chip select is high, the bus is not driven, and boot_done, opt_valid and rd_ready are all low.
- R2: The first bus transaction after reset is a wake command. It lasts two cycles and carries the opcode 0xAB, high nibble first, with the bus driven in both cycles. Chip select goes high for at least one cycle between any two transactions.
- R3: Every read transaction has the same shape. It starts with opcode 0xEB in two nibbles, high first. Then come six address nibbles and DUMMY_CYCLES turnaround cycles, then the data, one nibble per cycle with the most significant nibble of each word first. The bus is driven only during the opcode and address cycles.
- R4: The reads come in a fixed order: one word at CFG_ADDR, then BL_WORDS words at BL_ADDR, then one word at OPT_ADDR, then pages 0 to PREFETCH_PAGES-1 in ascending order. Each page read has 256 words at FW_BASE + page*0x400. The address is sent most significant nibble first, and each transaction lasts exactly 8+DUMMY_CYCLES+8*words cycles.
- R5: cfg_word shows the configuration word exactly as it was received, and it does not change once boot_done is high.
- R6: opt_valid is high for exactly one cycle, in the cycle after the last option nibble is taken. In that cycle opt_word holds the unscrambled option word. boot_done rises in the following cycle and then stays high.
- R7: A firmware word received at physical word index p of a page is stored at logical index l. Bit i of l equals bit WORD_PERM[i] of p.
- R8: In a stored firmware word, bit 8*b+i is the received bit 8*b+BYTE_PERM[b][i], for byte lane b (0 to 3, where lane b is data bits [8b+7:8b]) and bit i (0 to 7).
- R9: rd_ready is high in the same cycle as rd_req only when boot_done is high and the page of rd_addr (rd_addr[AW-1:8]) is loaded. In that case rd_data is the logical word at rd_addr.
- R10: After the boot sequence, a request to a page that is not loaded starts a 256-word read of that page. No bus transaction takes place unless a request needs one.
- R11: A request made before boot_done, or one made to a page still waiting in the prefetch, gets no ready until that page has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus nibble per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| qspi_cs_n | output | 1 | Flash chip select, active low |
| qspi_io_o | output | 4 | Nibble driven towards the flash |
| qspi_io_oe | output | 1 | High while the block drives the data lines |
| qspi_io_i | input | 4 | Nibble returned by the flash |
| cfg_word | output | 32 | Captured factory configuration word |
| opt_word | output | 32 | Option word forwarded to protection logic |
| opt_valid | output | 1 | One-cycle strobe marking opt_word valid |
| boot_done | output | 1 | Boot sequence finished; stays high |
| rd_req | input | 1 | Fetch request |
| rd_addr | input | AW | Logical firmware word index (page, word) |
| rd_ready | output | 1 | Requested word is available this cycle |
| rd_data | output | 32 | Descrambled firmware word |

## Verification
The bench builds the block with four pages and a prefetch of two. With these values one run covers three cases: a request that waits through the boot prefetch, reads of pages already loaded, and on-demand fills of pages 3 and then 2. A turnaround of four cycles and an eight-word boot loader region keep the header and region lengths distinct, so a count that is off by one shows up. Both shuffle tables are given as non-trivial permutations and are checked as bijections. Reads at word indices 0, 255 and every power of two then touch each word-address bit and each byte lane.

// File: rtl/qfb_pkg.sv
package qfb_pkg;

    typedef enum logic [1:0] {
        ST_GAP  = 2'd0,
        ST_WAKE = 2'd1,
        ST_XFER = 2'd2,
        ST_IDLE = 2'd3
    } st_e;

    typedef enum logic [1:0] {
        RG_CFG = 2'd0,
        RG_BL  = 2'd1,
        RG_OPT = 2'd2,
        RG_FW  = 2'd3
    } region_e;

    localparam logic [7:0] OP_WAKE = 8'hAB;
    localparam logic [7:0] OP_READ = 8'hEB;

endpackage

// File: rtl/qfb_descramble.sv
module qfb_descramble #(
    parameter logic [7:0][2:0]      WORD_PERM = {3'd2, 3'd5, 3'd7, 3'd1, 3'd4, 3'd0, 3'd6, 3'd3},
    parameter logic [3:0][7:0][2:0] BYTE_PERM = {
        3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7,
        3'd6, 3'd7, 3'd4, 3'd5, 3'd2, 3'd3, 3'd0, 3'd1,
        3'd3, 3'd2, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4,
        3'd5, 3'd0, 3'd7, 3'd2, 3'd1, 3'd4, 3'd3, 3'd6}
) (
    input  logic [7:0]  phys_idx,
    input  logic [31:0] raw,
    output logic [7:0]  log_idx,
    output logic [31:0] data
);
    // word index: gather each logical bit from its physical position
    for (genvar i = 0; i < 8; i++) begin : g_idx
        assign log_idx[i] = phys_idx[WORD_PERM[i]];
    end

    // data: each byte lane has its own shuffle
    for (genvar b = 0; b < 4; b++) begin : g_lane
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign data[8*b+i] = raw[8*b+BYTE_PERM[b][i]];
        end
    end
endmodule

// File: rtl/qfb_shadow_ram.sv
module qfb_shadow_ram #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/qfb_boot_fetch.sv
module qfb_boot_fetch
    import qfb_pkg::*;
#(
    parameter int NUM_PAGES      = 4,
    parameter int PREFETCH_PAGES = 2,
    parameter int DUMMY_CYCLES   = 4,
    parameter int BL_WORDS       = 8,
    parameter logic [23:0] CFG_ADDR = 24'h000400,
    parameter logic [23:0] BL_ADDR  = 24'h000800,
    parameter logic [23:0] OPT_ADDR = 24'h004000,
    parameter logic [23:0] FW_BASE  = 24'h010000,
    parameter logic [7:0][2:0]      WORD_PERM = {3'd2, 3'd5, 3'd7, 3'd1, 3'd4, 3'd0, 3'd6, 3'd3},
    parameter logic [3:0][7:0][2:0] BYTE_PERM = {
        3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7,
        3'd6, 3'd7, 3'd4, 3'd5, 3'd2, 3'd3, 3'd0, 3'd1,
        3'd3, 3'd2, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4,
        3'd5, 3'd0, 3'd7, 3'd2, 3'd1, 3'd4, 3'd3, 3'd6},
    localparam int PGW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int AW  = PGW + 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          qspi_cs_n,
    output logic [3:0]    qspi_io_o,
    output logic          qspi_io_oe,
    input  logic [3:0]    qspi_io_i,
    output logic [31:0]   cfg_word,
    output logic [31:0]   opt_word,
    output logic          opt_valid,
    output logic          boot_done,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ready,
    output logic [31:0]   rd_data
);
    localparam int PAGE_WORDS = 256;
    localparam int HDR        = 8 + DUMMY_CYCLES;
    localparam int MAXW       = (BL_WORDS > PAGE_WORDS) ? BL_WORDS : PAGE_WORDS;
    localparam int CW         = $clog2(HDR + 8 * MAXW + 1);
    localparam int SW         = $clog2(4 + PREFETCH_PAGES + 1);
    localparam int DEPTH      = NUM_PAGES * PAGE_WORDS;

    localparam logic [CW-1:0] LAST_ONE = CW'(HDR + 7);
    localparam logic [CW-1:0] LAST_BL  = CW'(HDR + 8 * BL_WORDS - 1);
    localparam logic [CW-1:0] LAST_PG  = CW'(HDR + 8 * PAGE_WORDS - 1);
    localparam logic [SW-1:0] STEP_FW  = SW'(4);
    localparam logic [SW-1:0] STEP_END = SW'(4 + PREFETCH_PAGES);

    typedef struct packed {
        st_e                  st;
        region_e              rg;
        logic [SW-1:0]        step;
        logic [CW-1:0]        cnt;
        logic [CW-1:0]        last;
        logic [23:0]          addr;
        logic [PGW-1:0]       page;
        logic [27:0]          sh;
        logic [31:0]          cfg;
        logic [31:0]          opt;
        logic                 opt_v;
        logic                 done;
        logic [NUM_PAGES-1:0] valid;
    } regs_t;

    regs_t r_q, r_d;

    logic [10:0]    k;
    logic           data_ph, word_end;
    logic [31:0]    full_word, clean_word;
    logic [7:0]     log_idx;
    logic [PGW-1:0] rd_page;
    logic           wr_en;

    logic           go;
    region_e        go_rg;
    logic [23:0]    go_addr;
    logic [CW-1:0]  go_last;
    logic [PGW-1:0] go_page;

    assign k         = 11'(r_q.cnt - CW'(HDR));
    assign data_ph   = (r_q.st == ST_XFER) && (r_q.cnt >= CW'(HDR));
    assign word_end  = data_ph && (k[2:0] == 3'b111);
    assign full_word = {r_q.sh, qspi_io_i};
    assign rd_page   = rd_addr[AW-1:8];

    qfb_descramble #(
        .WORD_PERM (WORD_PERM),
        .BYTE_PERM (BYTE_PERM)
    ) u_desc (
        .phys_idx (k[10:3]),
        .raw      (full_word),
        .log_idx  (log_idx),
        .data     (clean_word)
    );

    qfb_shadow_ram #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr ({r_q.page, log_idx}),
        .wdata (clean_word),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        r_d       = r_q;
        r_d.opt_v = 1'b0;
        r_d.done  = r_q.done | r_q.opt_v;
        wr_en     = 1'b0;
        go        = 1'b0;
        go_rg     = RG_CFG;
        go_addr   = CFG_ADDR;
        go_last   = LAST_ONE;
        go_page   = '0;

        case (r_q.st)
            ST_GAP: begin
                if (r_q.step == SW'(0)) begin
                    r_d.st  = ST_WAKE;
                    r_d.cnt = '0;
                end else if (r_q.step == SW'(1)) begin
                    go = 1'b1;
                end else if (r_q.step == SW'(2)) begin
                    go      = 1'b1;
                    go_rg   = RG_BL;
                    go_addr = BL_ADDR;
                    go_last = LAST_BL;
                end else if (r_q.step == SW'(3)) begin
                    go      = 1'b1;
                    go_rg   = RG_OPT;
                    go_addr = OPT_ADDR;
                end else if (r_q.step < STEP_END) begin
                    go      = 1'b1;
                    go_rg   = RG_FW;
                    go_page = PGW'(r_q.step - STEP_FW);
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_WAKE: begin
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(1)) begin
                    r_d.st   = ST_GAP;
                    r_d.step = SW'(1);
                    r_d.cnt  = '0;
                end
            end
            ST_IDLE: begin
                if (rd_req && r_q.done && !r_q.valid[rd_page]) begin
                    go      = 1'b1;
                    go_rg   = RG_FW;
                    go_page = rd_page;
                end
            end
            default: begin
                r_d.cnt = r_q.cnt + CW'(1);
                if (data_ph) r_d.sh = full_word[27:0];
                if (word_end) begin
                    case (r_q.rg)
                        RG_CFG: r_d.cfg = full_word;
                        RG_OPT: begin
                            r_d.opt   = full_word;
                            r_d.opt_v = 1'b1;
                        end
                        RG_FW:  wr_en = 1'b1;
                        default: ;
                    endcase
                end
                if (r_q.cnt == r_q.last) begin
                    r_d.st  = ST_GAP;
                    r_d.cnt = '0;
                    if (r_q.rg == RG_FW) r_d.valid[r_q.page] = 1'b1;
                    if (r_q.step < STEP_END) r_d.step = r_q.step + SW'(1);
                end
            end
        endcase

        if (go) begin
            r_d.st   = ST_XFER;
            r_d.cnt  = '0;
            r_d.rg   = go_rg;
            r_d.page = go_page;
            r_d.last = (go_rg == RG_FW) ? LAST_PG : go_last;
            r_d.addr = (go_rg == RG_FW)
                     ? FW_BASE + {{(14-PGW){1'b0}}, go_page, 10'b0}
                     : go_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_GAP;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        qspi_io_o = 4'h0;
        if (r_q.st == ST_WAKE) begin
            qspi_io_o = (r_q.cnt == '0) ? OP_WAKE[7:4] : OP_WAKE[3:0];
        end else if (r_q.st == ST_XFER && r_q.cnt < CW'(8)) begin
            case (r_q.cnt[2:0])
                3'd0: qspi_io_o = OP_READ[7:4];
                3'd1: qspi_io_o = OP_READ[3:0];
                3'd2: qspi_io_o = r_q.addr[23:20];
                3'd3: qspi_io_o = r_q.addr[19:16];
                3'd4: qspi_io_o = r_q.addr[15:12];
                3'd5: qspi_io_o = r_q.addr[11:8];
                3'd6: qspi_io_o = r_q.addr[7:4];
                default: qspi_io_o = r_q.addr[3:0];
            endcase
        end
    end

    assign qspi_cs_n  = !(r_q.st == ST_WAKE || r_q.st == ST_XFER);
    assign qspi_io_oe = (r_q.st == ST_WAKE) || (r_q.st == ST_XFER && r_q.cnt < CW'(8));
    assign cfg_word   = r_q.cfg;
    assign opt_word   = r_q.opt;
    assign opt_valid  = r_q.opt_v;
    assign boot_done  = r_q.done;
    assign rd_ready   = rd_req && r_q.done && r_q.valid[rd_page];
endmodule

// File: rtl/qfb_checker.sv
module qfb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        qspi_cs_n,
    input logic        qspi_io_oe,
    input logic        opt_valid,
    input logic        boot_done,
    input logic        rd_req,
    input logic        rd_ready,
    input logic [31:0] cfg_word
);
    assert_oe_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        qspi_io_oe |-> !qspi_cs_n);

    assert_ready_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (boot_done && rd_req));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);

    assert_done_after_opt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_done) |-> $past(opt_valid));

    assert_opt_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        opt_valid |=> !opt_valid);

    assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> $stable(cfg_word));
endmodule

bind qfb_boot_fetch qfb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .qspi_cs_n  (qspi_cs_n),
    .qspi_io_oe (qspi_io_oe),
    .opt_valid  (opt_valid),
    .boot_done  (boot_done),
    .rd_req     (rd_req),
    .rd_ready   (rd_ready),
    .cfg_word   (cfg_word)
);

// File: tb/tb_qfb_boot_fetch.sv
module tb_qfb_boot_fetch;
    localparam int NP  = 4;
    localparam int PF  = 2;
    localparam int DUM = 4;
    localparam int BLW = 8;
    localparam int HDR = 8 + DUM;
    localparam int AW  = 10;
    localparam int CFG_A = 'h000400;
    localparam int BL_A  = 'h000800;
    localparam int OPT_A = 'h004000;
    localparam int FW_A  = 'h010000;
    localparam logic [31:0] CFG_VAL = 32'h5EC0_1D27;
    localparam logic [31:0] OPT_VAL = 32'h33CC_A55A;
    localparam logic [7:0][2:0] WP = {3'd2, 3'd5, 3'd7, 3'd1, 3'd4, 3'd0, 3'd6, 3'd3};
    localparam logic [3:0][7:0][2:0] BP = {
        3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7,
        3'd6, 3'd7, 3'd4, 3'd5, 3'd2, 3'd3, 3'd0, 3'd1,
        3'd3, 3'd2, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4,
        3'd5, 3'd0, 3'd7, 3'd2, 3'd1, 3'd4, 3'd3, 3'd6};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          cs_n, oe, opt_valid, boot_done, rd_ready;
    logic [3:0]    io_o;
    logic [3:0]    io_i = 4'h0;
    logic [31:0]   cfg_word, opt_word, rd_data;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;

    qfb_boot_fetch #(
        .NUM_PAGES(NP), .PREFETCH_PAGES(PF), .DUMMY_CYCLES(DUM), .BL_WORDS(BLW),
        .CFG_ADDR(24'(CFG_A)), .BL_ADDR(24'(BL_A)), .OPT_ADDR(24'(OPT_A)), .FW_BASE(24'(FW_A)),
        .WORD_PERM(WP), .BYTE_PERM(BP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .qspi_cs_n(cs_n), .qspi_io_o(io_o), .qspi_io_oe(oe),
        .qspi_io_i(io_i), .cfg_word(cfg_word), .opt_word(opt_word), .opt_valid(opt_valid),
        .boot_done(boot_done), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_data(rd_data)
    );

    int errors = 0;
    int checks = 0;
    int phys2log [256];
    int q_op[$], q_addr[$], q_words[$];
    int cur_op, cur_addr, cur_words;
    bit cur_ok = 1'b0;
    int cyc = 0;
    bit done_exp = 1'b0, optv_exp = 1'b0;
    bit loaded [NP];
    bit finished = 1'b0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] logical_word(int idx);
        logic [31:0] v;
        v = 32'(idx);
        return (v * 32'h9E37_79B1) ^ 32'hC0FF_EE00;
    endfunction

    function automatic logic [31:0] scramble(logic [31:0] l);
        logic [31:0] s;
        s = '0;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 8; i++)
                s[8*b + int'(BP[b][i])] = l[8*b + i];
        return s;
    endfunction

    function automatic logic [31:0] flash_word(int a);
        int p, q;
        if (a == CFG_A) return CFG_VAL;
        if (a == OPT_A) return OPT_VAL;
        if (a >= BL_A && a < BL_A + 4*BLW) return 32'hB000_0000 | 32'(a);
        if (a >= FW_A) begin
            p = (a - FW_A) >> 10;
            q = (a >> 2) & 255;
            return scramble(logical_word(p*256 + phys2log[q]));
        end
        return 32'h0;
    endfunction

    task automatic push(int op, int addr, int words);
        q_op.push_back(op);
        q_addr.push_back(addr);
        q_words.push_back(words);
    endtask

    // cycle-level bus and port model, sampled away from the active edge
    always @(negedge clk) begin
        bit   exp_rdy, exp_oe, wake;
        int   pg, kk;
        logic [31:0] w;
        if (!rst_n) begin
            chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
            chk(oe == 1'b0, "R1", "io_oe in reset", oe, 0);
            chk(boot_done == 1'b0, "R1", "boot_done in reset", boot_done, 0);
            chk(opt_valid == 1'b0, "R1", "opt_valid in reset", opt_valid, 0);
            chk(rd_ready == 1'b0, "R1", "rd_ready in reset", rd_ready, 0);
            cyc = 0;
        end else if (!finished) begin
            chk(opt_valid == optv_exp, "R6", "opt_valid", opt_valid, optv_exp);
            chk(boot_done == done_exp, "R6", "boot_done", boot_done, done_exp);
            if (optv_exp) chk(opt_word == OPT_VAL, "R6", "opt_word", opt_word, OPT_VAL);
            if (done_exp) chk(cfg_word == CFG_VAL, "R5", "cfg_word", cfg_word, CFG_VAL);
            pg = int'(rd_addr) >> 8;
            exp_rdy = rd_req && done_exp && loaded[pg];
            if (rd_req && !loaded[pg] && pg >= PF)
                chk(rd_ready == exp_rdy, "R10", "rd_ready during fill", rd_ready, exp_rdy);
            else if (rd_req && !exp_rdy)
                chk(rd_ready == exp_rdy, "R11", "rd_ready while waiting", rd_ready, exp_rdy);
            else
                chk(rd_ready == exp_rdy, "R9", "rd_ready", rd_ready, exp_rdy);
            if (exp_rdy && rd_ready)
                chk(rd_data == logical_word(int'(rd_addr)), "R7+R8", "rd_data",
                    rd_data, logical_word(int'(rd_addr)));

            optv_exp = 1'b0;
            done_exp = done_exp | (opt_valid && done_exp == 1'b0 && 1'b0);
            if (!cs_n) begin
                if (cyc == 0) begin
                    if (q_op.size() == 0) begin
                        chk(1'b0, "R10", "unexpected bus transaction", 1, 0);
                        cur_ok = 1'b0;
                    end else begin
                        cur_op = q_op.pop_front();
                        cur_addr = q_addr.pop_front();
                        cur_words = q_words.pop_front();
                        cur_ok = 1'b1;
                    end
                end
                if (cur_ok) begin
                    wake = (cur_words == 0);
                    exp_oe = wake ? 1'b1 : (cyc < 8);
                    chk(oe == exp_oe, wake ? "R2" : "R3", "io_oe", oe, exp_oe);
                    if (cyc < 2)
                        chk(io_o == 4'((cur_op >> (4*(1-cyc))) & 15), wake ? "R2" : "R3",
                            "opcode nibble", io_o, (cur_op >> (4*(1-cyc))) & 15);
                    else if (!wake && cyc < 8)
                        chk(io_o == 4'((cur_addr >> (4*(7-cyc))) & 15), "R4",
                            "address nibble", io_o, (cur_addr >> (4*(7-cyc))) & 15);
                    if (!wake && cyc >= HDR) begin
                        kk = cyc - HDR;
                        w = flash_word(cur_addr + 4*(kk/8));
                        io_i = w[4*(7 - kk%8) +: 4];
                        if (cyc == HDR + 8*cur_words - 1) begin
                            if (cur_addr == OPT_A) optv_exp = 1'b1;
                            if (cur_addr >= FW_A) loaded[(cur_addr - FW_A) >> 10] = 1'b1;
                        end
                    end
                end
                cyc++;
            end else begin
                chk(oe == 1'b0, "R3", "io_oe with cs_n high", oe, 0);
                if (cyc > 0 && cur_ok) begin
                    kk = (cur_words == 0) ? 2 : HDR + 8*cur_words;
                    chk(cyc == kk, "R4", "transaction length", cyc, kk);
                end
                cyc = 0;
            end
        end
    end

    // boot_done follows the opt_valid strobe by one cycle
    always @(negedge clk) begin
        if (rst_n && opt_valid) done_exp <= 1'b1;
    end

    task automatic rd(int a, output int waited);
        @(posedge clk); #1;
        rd_req = 1'b1;
        rd_addr = AW'(a);
        waited = 0;
        forever begin
            @(negedge clk);
            if (rd_ready) break;
            waited++;
        end
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    initial begin
        int seen, n, wt, q;
        // table checks: both shuffles must be bijections
        seen = 0;
        for (int i = 0; i < 8; i++) seen |= 1 << int'(WP[i]);
        chk(seen == 255, "R7", "word permutation bijective", seen, 255);
        for (int b = 0; b < 4; b++) begin
            seen = 0;
            for (int i = 0; i < 8; i++) seen |= 1 << int'(BP[b][i]);
            chk(seen == 255, "R8", "byte permutation bijective", seen, 255);
        end
        for (int l = 0; l < 256; l++) phys2log[l] = -1;
        for (int l = 0; l < 256; l++) begin
            q = 0;
            for (int i = 0; i < 8; i++) if ((l >> i) & 1) q |= 1 << int'(WP[i]);
            phys2log[q] = l;
        end
        n = 0;
        for (int p = 0; p < 256; p++) if (phys2log[p] >= 0) n++;
        chk(n == 256, "R7", "inverse index table complete", n, 256);

        push('hAB, 0, 0);
        push('hEB, CFG_A, 1);
        push('hEB, BL_A, BLW);
        push('hEB, OPT_A, 1);
        for (int p = 0; p < PF; p++) push('hEB, FW_A + p*1024, 256);

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        rd(5, wt);
        chk(wt > 0, "R11", "early request waited", wt, 1);
        rd(0, wt);
        chk(wt == 0, "R9", "loaded page immediate", wt, 0);
        rd(255, wt);
        for (int s = 0; s < 8; s++) rd(1 << s, wt);
        rd(256 + 0, wt);
        rd(256 + 170, wt);
        rd(256 + 255, wt);

        repeat (200) @(posedge clk);
        chk(q_op.size() == 0, "R10", "no pending transactions", q_op.size(), 0);

        push('hEB, FW_A + 3*1024, 256);
        rd(3*256 + 17, wt);
        chk(wt >= HDR + 2048, "R10", "demand fill latency", wt, HDR + 2048);
        rd(3*256 + 0, wt);
        rd(3*256 + 255, wt);
        chk(wt == 0, "R9", "filled page immediate", wt, 0);

        push('hEB, FW_A + 2*1024, 256);
        rd(2*256 + 200, wt);
        for (int s = 0; s < 8; s++) rd(2*256 + (1 << s), wt);
        rd(256 + 3, wt);
        chk(wt == 0, "R9", "prefetched page immediate", wt, 0);

        repeat (20) @(posedge clk);
        chk(q_op.size() == 0, "R10", "all fills consumed", q_op.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule